// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small processor core. It has three sources: an external pin, a timer overflow pulse and an analog conversion-done pulse. Each source has a pending flag and a per-source enable, and one master enable gates all of them. The external pin is synchronized and then passed through an edge detector. A 2-bit mode selects rising, falling or both edges, or turns the pin off.

Service decisions are made only when the core presents its periodic phase strobe. On a strobe, if the master enable is set and the return stack is not full, the highest-priority source that is both pending and enabled is taken. The block then raises a one-clock take pulse together with that source's fixed vector address. In the same cycle it clears the serviced flag and the master enable, which stops nesting. Requests that arrive while service is blocked stay latched in their flags. The core's return-from-interrupt pulse sets the master enable again. Software writes the enables, the master bit, the edge mode and the pending flags through two write strobes.

Top module: `irqc_top`

## Requirements
- R1: After reset, all pending flags, all source enables and the master enable are 0, the edge mode is off (code 00), `take_irq` is 0 and `vec_addr` is 0.
- R2: The edge mode code on `cfg_edge` sets the external flag (bit 0) on these pin edges: 00 on no edge, 01 on a low-to-high edge, 10 on a high-to-low edge, 11 on either edge.
- R3: An active edge on `ext_pin` is visible in `irq_flags[0]` no earlier than the third and no later than the third rising clock edge after the pin change. The pin change is made half a cycle before the first of those edges, which gives 2 to 3 clocks of latency.
- R4: A one-cycle pulse on `tmr_ovf` sets `irq_flags[1]`, and one on `adc_eoc` sets `irq_flags[2]`, on the next clock edge. This happens whatever the state of the enables or the master enable.
- R5: `take_irq` is raised only in the cycle after a clock on which `phase_stb` was 1, the master enable was 1, and at least one flag had its enable bit set.
- R6: When several enabled flags are pending, the source taken is the external one first, then the timer (bit 1), then conversion-done (bit 2).
- R7: `take_irq` lasts exactly one clock, and `vec_addr` shows 0x004 (external), 0x008 (timer) or 0x00C (conversion-done) in that same cycle.
- R8: In the cycle `take_irq` is 1, the serviced flag reads 0 and every other flag keeps its value.
- R9: In the cycle `take_irq` is 1, the master enable reads 0. Requests that arrive later are still latched, and they are taken on a strobe once the master enable is 1 again.
- R10: While `stack_full` is 1, no strobe produces `take_irq`, and the flags and master enable are left unchanged.
- R11: A `reti` pulse sets the master enable on the next clock edge.
- R12: A `flag_we` pulse loads `flag_wdata` into the pending flags (bit 0 external, 1 timer, 2 conversion-done).
- R13: With the master enable at 0, no strobe produces `take_irq`, whatever the flags and per-source enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 1 | Asynchronous external request pin |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_eoc | input | 1 | Conversion-done pulse |
| phase_stb | input | 1 | Periodic service-sampling strobe from the core |
| stack_full | input | 1 | Core return stack has no free entry |
| reti | input | 1 | Return-from-interrupt pulse |
| cfg_we | input | 1 | Writes enables, master enable and edge mode |
| cfg_en | input | 3 | Per-source enables (bit 0 ext, 1 timer, 2 conversion) |
| cfg_gie | input | 1 | Master enable value to write |
| cfg_edge | input | 2 | Edge mode code |
| flag_we | input | 1 | Writes the pending flags |
| flag_wdata | input | 3 | Pending flag value to write |
| take_irq | output | 1 | One-clock take-interrupt pulse |
| vec_addr | output | 12 | Vector of the taken source |
| irq_flags | output | 3 | Pending flags |
| irq_gie | output | 1 | Master enable |

## Verification
A wrong priority order or a wrong vector table shows up at the take pulse that follows the strobe. The bench sweeps every combination of pending flags and enables, so any mis-ranked pair is caught within one strobe. Stale state appears on `irq_flags` and `irq_gie` in the same cycle as the take pulse. Examples are a flag that is not cleared on service, a master enable that stays set, or a latched request that is lost while blocked. An off-by-one synchronizer depth or a wrong edge decode moves the external flag by one clock, or sets it on the wrong edge. Both are visible three clocks after the pin changes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned NSRC    = 3;
    localparam int unsigned SRC_EXT = 0;
    localparam int unsigned SRC_TMR = 1;
    localparam int unsigned SRC_ADC = 2;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    typedef logic [NSRC-1:0] src_vec_t;

endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det
    import irqc_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       hit
);

    localparam int unsigned MSB = STAGES - 1;

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;
    logic              rise, fall;

    // synchronizer chain, depth chosen by parameter
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            assign sync_d[g] = pin;
        end else begin : g_rest
            assign sync_d[g] = sync_q[g-1];
        end
    end

    always_comb begin
        prev_d = sync_q[MSB];
        rise   = sync_q[MSB] & ~prev_q;
        fall   = ~sync_q[MSB] & prev_q;
        case (mode)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    // lowest index wins
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
        any = found;
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
#(
    parameter int unsigned VEC_W       = 12,
    parameter int unsigned VEC_BASE    = 4,
    parameter int unsigned VEC_STEP    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             tmr_ovf,
    input  logic             adc_eoc,
    input  logic             phase_stb,
    input  logic             stack_full,
    input  logic             reti,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_en,
    input  logic             cfg_gie,
    input  logic [1:0]       cfg_edge,
    input  logic             flag_we,
    input  logic [2:0]       flag_wdata,
    output logic             take_irq,
    output logic [VEC_W-1:0] vec_addr,
    output logic [2:0]       irq_flags,
    output logic             irq_gie
);

    typedef struct packed {
        src_vec_t         flag;
        src_vec_t         en;
        logic             gie;
        edge_mode_e       mode;
        logic             take;
        logic [VEC_W-1:0] vec;
    } state_t;

    state_t s_d, s_q;

    logic             ext_hit;
    src_vec_t         events;
    src_vec_t         ready;
    src_vec_t         gnt;
    logic             any_ready;
    logic             service;
    logic [VEC_W-1:0] sel_vec;
    logic [VEC_W-1:0] vec_tbl [NSRC];

    irqc_edge_det #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .mode  (s_q.mode),
        .hit   (ext_hit)
    );

    // fixed vector per source, spaced by VEC_STEP
    for (genvar g = 0; g < NSRC; g++) begin : g_vec
        assign vec_tbl[g] = VEC_W'(VEC_BASE + g * VEC_STEP);
    end

    assign events[SRC_EXT] = ext_hit;
    assign events[SRC_TMR] = tmr_ovf;
    assign events[SRC_ADC] = adc_eoc;

    assign ready = s_q.flag & s_q.en;

    irqc_prio #(
        .N (NSRC)
    ) u_prio (
        .req (ready),
        .gnt (gnt),
        .any (any_ready)
    );

    assign service = phase_stb & s_q.gie & ~stack_full & any_ready;

    always_comb begin
        sel_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (gnt[i]) sel_vec = sel_vec | vec_tbl[i];
        end
    end

    always_comb begin
        s_d      = s_q;
        s_d.take = 1'b0;
        if (cfg_we) begin
            s_d.en   = cfg_en;
            s_d.gie  = cfg_gie;
            s_d.mode = edge_mode_e'(cfg_edge);
        end
        if (reti) s_d.gie = 1'b1;
        if (flag_we) s_d.flag = flag_wdata;
        if (service) begin
            s_d.gie  = 1'b0;
            s_d.flag = s_d.flag & ~gnt;
            s_d.take = 1'b1;
            s_d.vec  = sel_vec;
        end
        // a new event is never lost, even against a clear
        s_d.flag = s_d.flag | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{flag: '0, en: '0, gie: 1'b0, mode: EDGE_OFF,
                     take: 1'b0, vec: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign take_irq  = s_q.take;
    assign vec_addr  = s_q.vec;
    assign irq_flags = s_q.flag;
    assign irq_gie   = s_q.gie;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int unsigned VEC_W    = 12,
    parameter int unsigned VEC_BASE = 4,
    parameter int unsigned VEC_STEP = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_stb,
    input logic             stack_full,
    input logic             reti,
    input logic             take_irq,
    input logic [VEC_W-1:0] vec_addr,
    input logic             irq_gie
);

    localparam logic [VEC_W-1:0] V0 = VEC_W'(VEC_BASE);
    localparam logic [VEC_W-1:0] V1 = VEC_W'(VEC_BASE + VEC_STEP);
    localparam logic [VEC_W-1:0] V2 = VEC_W'(VEC_BASE + 2 * VEC_STEP);

    assert_take_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);

    assert_vec_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (vec_addr == V0 || vec_addr == V1 || vec_addr == V2));

    assert_take_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> ($past(phase_stb) && $past(irq_gie)));

    assert_stack_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !$past(stack_full));

    assert_gie_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> !irq_gie);

    assert_reti_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        reti |=> (irq_gie || take_irq));

endmodule

bind irqc_top irqc_chk #(
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_stb  (phase_stb),
    .stack_full (stack_full),
    .reti       (reti),
    .take_irq   (take_irq),
    .vec_addr   (vec_addr),
    .irq_gie    (irq_gie)
);

// File: tb/sim_irqc_top.sv
`timescale 1ns/1ps
module sim_irqc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b0, tmr_ovf = 1'b0, adc_eoc = 1'b0;
    logic        phase_stb = 1'b0, stack_full = 1'b0, reti = 1'b0;
    logic        cfg_we = 1'b0, cfg_gie = 1'b0, flag_we = 1'b0;
    logic [2:0]  cfg_en = '0, flag_wdata = '0;
    logic [1:0]  cfg_edge = '0;
    logic        take_irq;
    logic [11:0] vec_addr;
    logic [2:0]  irq_flags;
    logic        irq_gie;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    irqc_top u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_ovf(tmr_ovf),
        .adc_eoc(adc_eoc), .phase_stb(phase_stb), .stack_full(stack_full),
        .reti(reti), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_gie(cfg_gie),
        .cfg_edge(cfg_edge), .flag_we(flag_we), .flag_wdata(flag_wdata),
        .take_irq(take_irq), .vec_addr(vec_addr), .irq_flags(irq_flags),
        .irq_gie(irq_gie)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic set_regs(logic [2:0] fl, logic [2:0] en, logic gie, logic [1:0] md);
        cfg_we = 1'b1; cfg_en = en; cfg_gie = gie; cfg_edge = md;
        flag_we = 1'b1; flag_wdata = fl;
        tick();
        cfg_we = 1'b0; flag_we = 1'b0;
    endtask

    task automatic strobe();
        phase_stb = 1'b1;
        tick();
        phase_stb = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 take", int'(take_irq), 0);
        check("R1 flags", int'(irq_flags), 0);
        check("R1 gie", int'(irq_gie), 0);
        check("R1 vec", int'(vec_addr), 0);

        // R2, R3 edge modes on both pin directions
        for (int m = 0; m < 4; m++) begin
            set_regs(3'b000, 3'b000, 1'b0, 2'(m));
            ext_pin = 1'b1;
            tick(); tick();
            check("R3 not early rise", int'(irq_flags[0]), 0);
            tick();
            check("R2 rise", int'(irq_flags[0]), (m == 1 || m == 3) ? 1 : 0);
            tick(); tick();
            set_regs(3'b000, 3'b000, 1'b0, 2'(m));
            ext_pin = 1'b0;
            tick(); tick();
            check("R3 not early fall", int'(irq_flags[0]), 0);
            tick();
            check("R2 fall", int'(irq_flags[0]), (m == 2 || m == 3) ? 1 : 0);
            tick(); tick();
        end

        // R4 internal sources record with everything disabled
        set_regs(3'b000, 3'b000, 1'b0, 2'b00);
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
        check("R4 timer flag", int'(irq_flags), 2);
        adc_eoc = 1'b1; tick(); adc_eoc = 1'b0;
        check("R4 adc flag", int'(irq_flags), 6);

        // R12 direct flag write
        set_regs(3'b101, 3'b000, 1'b0, 2'b00);
        check("R12 flag write", int'(irq_flags), 5);

        // R5 R6 R7 R8 R9 exhaustive pending x enable sweep
        for (int p = 0; p < 8; p++) begin
            for (int e = 0; e < 8; e++) begin
                int rdy, win, exp_vec;
                rdy = p & e;
                win = -1;
                for (int i = 2; i >= 0; i--) if (rdy[i]) win = i;
                exp_vec = 4 + 4 * win;
                set_regs(3'(p), 3'(e), 1'b1, 2'b00);
                tick();
                check("R5 no take without strobe", int'(take_irq), 0);
                strobe();
                check("R5 take on strobe", int'(take_irq), (rdy != 0) ? 1 : 0);
                if (rdy != 0) begin
                    check("R6 R7 vector", int'(vec_addr), exp_vec);
                    check("R8 flag clear", int'(irq_flags), p & ~(1 << win));
                    check("R9 gie cleared", int'(irq_gie), 0);
                end else begin
                    check("R8 flags kept", int'(irq_flags), p);
                    check("R9 gie kept", int'(irq_gie), 1);
                end
                tick();
                check("R7 one clock", int'(take_irq), 0);
            end
        end

        // R13 master enable clear masks everything
        set_regs(3'b111, 3'b111, 1'b0, 2'b00);
        strobe();
        check("R13 masked", int'(take_irq), 0);
        check("R13 flags kept", int'(irq_flags), 7);

        // R10 stack full blocks
        set_regs(3'b011, 3'b111, 1'b1, 2'b00);
        stack_full = 1'b1;
        strobe();
        check("R10 blocked", int'(take_irq), 0);
        check("R10 flags kept", int'(irq_flags), 3);
        check("R10 gie kept", int'(irq_gie), 1);
        stack_full = 1'b0;
        strobe();
        check("R10 take after release", int'(take_irq), 1);
        check("R10 vector", int'(vec_addr), 4);

        // R9 latched while blocked, R11 reti reopens
        set_regs(3'b000, 3'b111, 1'b0, 2'b00);
        tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
        strobe();
        check("R9 no nesting", int'(take_irq), 0);
        check("R9 latched", int'(irq_flags), 2);
        reti = 1'b1; tick(); reti = 1'b0;
        check("R11 gie set", int'(irq_gie), 1);
        strobe();
        check("R9 serviced later", int'(take_irq), 1);
        check("R9 vector", int'(vec_addr), 8);
        check("R9 flag cleared", int'(irq_flags), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule